// File: doc/BRIEF.md
# Power Button Debounce and Interrupt

This block watches a single active-low power button and turns it into three views for the rest of the power controller. The first is a raw sense bit that shows the pin level after synchronisation, with no filtering. The second is a debounced turn-on request that the off-state sequencer uses to decide whether to power the system up. The third is a sticky interrupt flag that records every debounced press and every debounced release.

All timing runs from a 32.768 kHz tick enable, and the system clock samples it. A 2-bit setting chooses how long a press must last before it counts. A press can wait one of three lengths, and the turn-on request can also take the press at once, with no wait. A release always uses the short length. Software clears the flag with a one-cycle strobe, and the flag is also cleared when the system enters the off state. The mask input only hides the flag from the interrupt output. It never affects the turn-on request.

Top module: `pwrkey_debounce`

## Requirements
- R1: `sense` is 1 while the pin is low, 0 while it is high. It follows the pin through a two-flop synchroniser, so it changes two clock edges after the pin, with no debounce.
- R2: A press becomes the debounced pressed state after the synchronised pin has stayed low for a run of ticks set by `dbnc_sel`. Codes 0 and 1 use TICKS_SHORT (1024), code 2 uses TICKS_MID (4096) and code 3 uses TICKS_LONG (24576).
- R3: A release becomes the debounced released state after TICKS_SHORT ticks, whatever the value of `dbnc_sel`.
- R4: If the synchronised pin returns to the debounced level before the run completes, the debounced state does not change and the tick count starts again from zero.
- R5: Every change of the debounced state, a press or a release, sets `irq_flag` on the same clock edge.
- R6: `irq_flag` stays set until a clear or an off-state entry.
- R7: An `irq_clr` pulse clears `irq_flag` on the next edge. If a debounced edge falls in the same cycle, the flag stays set.
- R8: An `off_entry` pulse clears `irq_flag` on the next edge, unless a debounced edge falls in the same cycle.
- R9: With `dbnc_sel` = 0, `turn_on_req` equals `sense`, so it needs no debounce. With any other code, `turn_on_req` equals the debounced pressed state.
- R10: `irq_out` is `irq_flag` AND NOT `irq_mask`. The mask changes neither `irq_flag` nor `turn_on_req`.
- R11: The debounce counts advance only in cycles where `tick` is 1.
- R12: After reset, `sense`, `turn_on_req`, `irq_flag` and `irq_out` are 0, and the debounced state is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 32.768 kHz tick enable, one clock wide |
| btn_n | input | 1 | Raw button pin, low when pressed |
| dbnc_sel | input | 2 | Debounce setting code |
| irq_mask | input | 1 | Hides the flag from `irq_out` |
| irq_clr | input | 1 | Software clear strobe for the flag |
| off_entry | input | 1 | Strobe when the system enters the off state |
| sense | output | 1 | Synchronised pin level, 1 = pressed |
| turn_on_req | output | 1 | Debounced turn-on request |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_out | output | 1 | Interrupt output after the mask |

## Verification
The flag update can see a set from a completed debounce run and a software clear in the same cycle. The bench counts edges from the pin change so that `irq_clr` is high exactly on the edge where the press run completes. It then checks that the flag reads 1 afterwards. A second clear with no edge pending must bring the flag to 0. This shows that the earlier result came from the priority rule and not from a clear that was ignored.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;

    typedef enum logic [1:0] {
        SEL_IMMEDIATE = 2'd0,
        SEL_SHORT     = 2'd1,
        SEL_MID       = 2'd2,
        SEL_LONG      = 2'd3
    } dbnc_sel_e;

endpackage

// File: rtl/pwrkey_sync.sv
module pwrkey_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/pwrkey_filter.sv
module pwrkey_filter
    import pwrkey_pkg::*;
#(
    parameter int TICKS_SHORT = 1024,
    parameter int TICKS_MID   = 4096,
    parameter int TICKS_LONG  = 24576
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       pressed_i,
    input  logic [1:0] sel_i,
    output logic       stable_o,
    output logic       edge_o
);
    localparam int CW = $clog2(TICKS_LONG + 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(TICKS_SHORT - 1);
    localparam logic [CW-1:0] LAST_MID   = CW'(TICKS_MID - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(TICKS_LONG - 1);

    typedef struct packed {
        logic          stable;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t     st_d, st_q;
    logic [CW-1:0] last_tick;
    logic      edge_d;

    // Press length depends on the setting; release is always short.
    always_comb begin
        last_tick = LAST_SHORT;
        if (!st_q.stable) begin
            unique case (dbnc_sel_e'(sel_i))
                SEL_MID:  last_tick = LAST_MID;
                SEL_LONG: last_tick = LAST_LONG;
                default:  last_tick = LAST_SHORT;
            endcase
        end
    end

    always_comb begin
        st_d   = st_q;
        edge_d = 1'b0;
        if (pressed_i == st_q.stable) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == last_tick) begin
                st_d.stable = pressed_i;
                st_d.cnt    = '0;
                edge_d      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stable_o = st_q.stable;
    assign edge_o   = edge_d;
endmodule

// File: rtl/pwrkey_irq.sv
module pwrkey_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic off_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || off_i) begin
            st_d.flag = 1'b0;
        end
        if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/pwrkey_debounce.sv
module pwrkey_debounce
    import pwrkey_pkg::*;
#(
    parameter int TICKS_SHORT = 1024,
    parameter int TICKS_MID   = 4096,
    parameter int TICKS_LONG  = 24576,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       btn_n,
    input  logic [1:0] dbnc_sel,
    input  logic       irq_mask,
    input  logic       irq_clr,
    input  logic       off_entry,
    output logic       sense,
    output logic       turn_on_req,
    output logic       irq_flag,
    output logic       irq_out
);
    logic btn_level;
    logic pressed_sync;
    logic stable;
    logic edge_evt;

    pwrkey_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(btn_n),
        .level_o(btn_level)
    );

    assign pressed_sync = ~btn_level;

    pwrkey_filter #(
        .TICKS_SHORT(TICKS_SHORT),
        .TICKS_MID  (TICKS_MID),
        .TICKS_LONG (TICKS_LONG)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .pressed_i(pressed_sync),
        .sel_i    (dbnc_sel),
        .stable_o (stable),
        .edge_o   (edge_evt)
    );

    pwrkey_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (edge_evt),
        .clr_i (irq_clr),
        .off_i (off_entry),
        .flag_o(irq_flag)
    );

    assign sense       = pressed_sync;
    assign turn_on_req = (dbnc_sel_e'(dbnc_sel) == SEL_IMMEDIATE) ? pressed_sync : stable;
    assign irq_out     = irq_flag & ~irq_mask;
endmodule

// File: rtl/pwrkey_debounce_chk.sv
module pwrkey_debounce_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_clr,
    input logic off_entry,
    input logic pressed,
    input logic stable,
    input logic edge_evt,
    input logic irq_flag
);
    // R4: the debounced state only moves on a completed run, and then toward the input level
    assert_flip_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> (stable == $past(pressed)));
    assert_no_flip_without_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_evt |=> $stable(stable));
    // R5
    assert_flag_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> irq_flag);
    // R6
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr && !off_entry) |=> irq_flag);
    // R7
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !edge_evt) |=> !irq_flag);
    // R8
    assert_off_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (off_entry && !edge_evt) |=> !irq_flag);
endmodule

bind pwrkey_debounce pwrkey_debounce_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_clr  (irq_clr),
    .off_entry(off_entry),
    .pressed  (pressed_sync),
    .stable   (stable),
    .edge_evt (edge_evt),
    .irq_flag (irq_flag)
);

// File: tb/pwrkey_debounce_bench.sv
module pwrkey_debounce_bench;
    localparam int S = 8;
    localparam int M = 20;
    localparam int L = 40;

    logic clk = 1'b0;
    logic rst_n, tick, btn_n, irq_mask, irq_clr, off_entry;
    logic [1:0] dbnc_sel;
    logic sense, turn_on_req, irq_flag, irq_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwrkey_debounce #(
        .TICKS_SHORT(S),
        .TICKS_MID  (M),
        .TICKS_LONG (L)
    ) u_pwrkey_debounce (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .btn_n      (btn_n),
        .dbnc_sel   (dbnc_sel),
        .irq_mask   (irq_mask),
        .irq_clr    (irq_clr),
        .off_entry  (off_entry),
        .sense      (sense),
        .turn_on_req(turn_on_req),
        .irq_flag   (irq_flag),
        .irq_out    (irq_out)
    );

    // {sel[1:0], press, ticks[6:0]}
    localparam logic [9:0] VEC [0:7] = '{
        {2'd1, 1'b1, 7'(S)}, {2'd1, 1'b0, 7'(S)},
        {2'd2, 1'b1, 7'(M)}, {2'd2, 1'b0, 7'(S)},
        {2'd3, 1'b1, 7'(L)}, {2'd3, 1'b0, 7'(S)},
        {2'd0, 1'b1, 7'(S)}, {2'd0, 1'b0, 7'(S)}
    };

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; btn_n = 1'b1; dbnc_sel = 2'd0;
        irq_mask = 1'b0; irq_clr = 1'b0; off_entry = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R12 sense", sense, 1'b0);
        chk("R12 turn_on_req", turn_on_req, 1'b0);
        chk("R12 irq_flag", irq_flag, 1'b0);
        chk("R12 irq_out", irq_out, 1'b0);

        // Table walk: R2 press lengths, R3 release length, R9 turn-on view
        for (int i = 0; i < 8; i++) begin
            logic [1:0] sel;
            logic       press;
            int         n;
            sel   = VEC[i][9:8];
            press = VEC[i][7];
            n     = int'(VEC[i][6:0]);
            dbnc_sel = sel;
            pulse_clr();
            btn_n = ~press;
            step(n + 1);
            chk(press ? "R2 flag before run ends" : "R3 flag before run ends", irq_flag, 1'b0);
            chk("R9 turn_on_req before run ends", turn_on_req, press ? (sel == 2'd0) : (sel != 2'd0));
            step(1);
            chk(press ? "R2 flag after press run" : "R3 flag after release run", irq_flag, 1'b1);
            chk("R9 turn_on_req after run", turn_on_req, press);
        end

        // R6 sticky
        step(30);
        chk("R6 flag held", irq_flag, 1'b1);

        // R8 off entry
        off_entry = 1'b1;
        step(1);
        off_entry = 1'b0;
        chk("R8 off_entry clears", irq_flag, 1'b0);

        // R1 sense latency
        dbnc_sel = 2'd1;
        btn_n = 1'b0;
        step(1);
        chk("R1 sense after one edge", sense, 1'b0);
        step(1);
        chk("R1 sense after two edges", sense, 1'b1);
        step(S);
        chk("R5 flag on press", irq_flag, 1'b1);
        btn_n = 1'b1;
        step(S + 2);
        chk("R9 turn_on_req released", turn_on_req, 1'b0);

        // R7 clear alone, then clear colliding with a set
        pulse_clr();
        chk("R7 clear alone", irq_flag, 1'b0);
        btn_n = 1'b0;
        step(S + 1);
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
        chk("R7 set wins over clear", irq_flag, 1'b1);
        pulse_clr();
        chk("R7 clear after collision", irq_flag, 1'b0);
        btn_n = 1'b1;
        step(S + 2);
        chk("R5 flag on release", irq_flag, 1'b1);

        // R10 mask
        btn_n = 1'b0;
        step(S + 2);
        irq_mask = 1'b1;
        step(1);
        chk("R10 irq_out masked", irq_out, 1'b0);
        chk("R10 flag under mask", irq_flag, 1'b1);
        chk("R10 turn_on_req under mask", turn_on_req, 1'b1);
        irq_mask = 1'b0;
        step(1);
        chk("R10 irq_out unmasked", irq_out, 1'b1);

        // R4 short glitch, then full restart
        btn_n = 1'b1;
        step(S + 2);
        pulse_clr();
        btn_n = 1'b0;
        step(S - 2);
        btn_n = 1'b1;
        step(3 * S);
        chk("R4 glitch no flag", irq_flag, 1'b0);
        chk("R4 glitch no turn_on", turn_on_req, 1'b0);
        btn_n = 1'b0;
        step(S + 1);
        chk("R4 restart full length", irq_flag, 1'b0);
        step(1);
        chk("R4 restart completes", irq_flag, 1'b1);

        // R11 tick gating
        btn_n = 1'b1;
        step(S + 2);
        pulse_clr();
        dbnc_sel = 2'd3;
        tick = 1'b0;
        btn_n = 1'b0;
        step(3 * L);
        chk("R1 sense without ticks", sense, 1'b1);
        chk("R11 no count without tick", turn_on_req, 1'b0);
        chk("R11 no flag without tick", irq_flag, 1'b0);
        tick = 1'b1;
        step(L - 1);
        chk("R11 count resumes, not done", turn_on_req, 1'b0);
        step(1);
        chk("R11 count resumes, done", turn_on_req, 1'b1);
        chk("R5 flag after gated run", irq_flag, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule